// File: doc/BRIEF.md
# Descriptor Ring Pointer Controller

This block keeps the address bookkeeping for one channel of a descriptor-driven DMA engine. Software programs a descriptor-list base address as a high half and a low half, a tail (end) address and a ring length. Software also sets a run bit. The block then presents the address of the descriptor the engine should work on next. Each time the engine finishes a descriptor it pulses an advance strobe. The block then steps the pointer by one descriptor and wraps it back to the base after the last ring entry. The pointer stops moving while it sits on the tail.

Stopping and restarting the channel does not rewind it. On restart the pointer carries on from where it halted. It reloads from the base only if software rewrote the low base half during the stop. Base writes made while the channel runs are dropped. The stored low base is forced to data-bus alignment.

Top module: `desc_ring_ptr`

## Requirements
- R1: After reset the run bit, both base halves, the tail, the ring length and the current pointer are all zero, the "newly programmed" flag is clear and `idle` is 1.
- R2: Register map on the 3-bit register address: 0 = control (bit 0 is the run bit), 1 = base high half, 2 = base low half, 3 = tail, 4 = last ring index, 5 = current pointer low 32 bits. Writes to offsets 1 and 2 while the run bit is 1 leave both base halves unchanged.
- R3: The stored base low half has its low log2(DATA_BUS_BYTES) bits cleared, which is 3 bits for the default 8-byte bus.
- R4: A write to the base high half alone does not mark the base as newly programmed, so a restart after it keeps the current pointer where it was.
- R5: When the run bit goes from 0 to 1 after a base-low write made while stopped, the current pointer loads the stored base low half and the ring index returns to 0.
- R6: When the run bit goes from 0 to 1 with no base-low write during the stop, the current pointer keeps the value it had when the channel stopped.
- R7: The upper ADDR_W-32 bits of `cur_addr` always equal the stored base high half.
- R8: The tail register can be written whether or not the channel runs, reads back as written and drives `tail_ptr`.
- R9: While running and not idle, an advance strobe adds DESC_BYTES (16) to the current pointer.
- R10: An advance strobe at ring index equal to the last-ring-index register returns the pointer to the base low half and the index to 0.
- R11: `idle` is 1 exactly when the current pointer low half equals the tail. Advance strobes have no effect while idle or while the run bit is 0.
- R12: Offset 5 is read-only, so writes to it change nothing. Reads of offsets 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| advance | input | 1 | Engine strobe: one descriptor consumed |
| cur_addr | output | ADDR_W | Full current descriptor address |
| tail_ptr | output | 32 | Programmed tail address |
| idle | output | 1 | Current pointer has reached the tail |

## Verification
A wrong "newly programmed" flag becomes visible only at the next 0-to-1 transition of the run bit. It then shows as a pointer that reloads when it should resume, or the reverse, so the bench checks the pointer right after each restart. A wrong ring index does not show until the wrap cycle. The bench therefore drives enough advances to reach the wrap, and later advances that resume mid-ring after a stop. A base that was wrongly accepted while running shows on readback at once, and it also shows at the next wrap.

// File: rtl/ring_ptr_pkg.sv
// Shared register offsets for the descriptor ring pointer controller.
package ring_ptr_pkg;
    typedef enum logic [2:0] {
        RA_CTRL      = 3'd0,
        RA_BASE_HI   = 3'd1,
        RA_BASE_LO   = 3'd2,
        RA_TAIL      = 3'd3,
        RA_RING_LAST = 3'd4,
        RA_CUR_LO    = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/ring_ptr_regs.sv
// Software-visible state: run bit, base halves, tail, ring length and
// the "newly programmed" flag. Assumes one register write per cycle.
module ring_ptr_regs
    import ring_ptr_pkg::*;
#(
    parameter int HI_W       = 16,
    parameter int RING_W     = 8,
    parameter int ALIGN_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        waddr,
    input  logic [31:0]       wdata,
    output logic              run,
    output logic              start_pulse,
    output logic              fresh,
    output logic [HI_W-1:0]   base_hi,
    output logic [31:0]       base_lo,
    output logic [31:0]       tail,
    output logic [RING_W-1:0] ring_last
);
    logic wr_ctrl, wr_hi, wr_lo;

    // Decode writes; base writes count only while stopped.
    always_comb begin
        wr_ctrl     = we && (waddr == RA_CTRL);
        wr_hi       = we && (waddr == RA_BASE_HI) && !run;
        wr_lo       = we && (waddr == RA_BASE_LO) && !run;
        start_pulse = wr_ctrl && wdata[0] && !run;
    end

    // Register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b0;
            fresh     <= 1'b0;
            base_hi   <= '0;
            base_lo   <= '0;
            tail      <= '0;
            ring_last <= '0;
        end else begin
            if (wr_ctrl) run <= wdata[0];
            if (wr_hi) base_hi <= wdata[HI_W-1:0];
            if (wr_lo) base_lo <= {wdata[31:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
            if (we && waddr == RA_TAIL) tail <= wdata;
            if (we && waddr == RA_RING_LAST) ring_last <= wdata[RING_W-1:0];
            if (start_pulse) fresh <= 1'b0;
            else if (wr_lo)  fresh <= 1'b1;
        end
    end

    // R2: base halves frozen while running
    a_r2_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(base_lo) && $stable(base_hi)));
    // R4: a high-half write alone never raises the flag
    a_r4_hi_not_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == RA_BASE_HI && !fresh) |=> !fresh);
endmodule

// File: rtl/ring_ptr_cursor.sv
// Current descriptor pointer and ring index. Reloads on a fresh start,
// steps on advance, wraps at the last ring entry, holds when idle.
// Assumes DESC_BYTES is a multiple of the bus alignment.
module ring_ptr_cursor #(
    parameter int RING_W     = 8,
    parameter int DESC_BYTES = 16,
    parameter int ALIGN_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              start_pulse,
    input  logic              fresh,
    input  logic [31:0]       base_lo,
    input  logic [31:0]       tail,
    input  logic [RING_W-1:0] ring_last,
    input  logic              advance,
    output logic [31:0]       cur_lo,
    output logic              idle
);
    localparam logic [31:0] STEP = 32'(DESC_BYTES);
    logic [RING_W-1:0] idx;
    logic              step_ok;

    // Idle and step qualification.
    always_comb begin
        idle    = (cur_lo == tail);
        step_ok = run && advance && !idle;
    end

    // Pointer and index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lo <= '0;
            idx    <= '0;
        end else if (start_pulse && fresh) begin
            cur_lo <= base_lo;
            idx    <= '0;
        end else if (step_ok) begin
            if (idx == ring_last) begin
                cur_lo <= base_lo;
                idx    <= '0;
            end else begin
                cur_lo <= cur_lo + STEP;
                idx    <= idx + 1'b1;
            end
        end
    end

    // R5: fresh start loads the base
    a_r5_fresh_load: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && fresh) |=> (cur_lo == $past(base_lo)));
    // R6: plain restart resumes
    a_r6_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && !fresh) |=> $stable(cur_lo));
    // R11: no movement while idle or stopped
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((idle || !run) && !start_pulse) |=> $stable(cur_lo));
    // R9: non-wrapping step adds one descriptor
    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && idx != ring_last) |=> (cur_lo == $past(cur_lo) + STEP));
    // R3: pointer stays bus aligned
    a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cur_lo[ALIGN_BITS-1:0] == '0);
endmodule

// File: rtl/desc_ring_ptr.sv
// Top of the descriptor ring pointer controller: joins the register
// state and the cursor and provides the read mux. Reads are combinational.
module desc_ring_ptr
    import ring_ptr_pkg::*;
#(
    parameter int ADDR_W         = 48,
    parameter int DATA_BUS_BYTES = 8,
    parameter int DESC_BYTES     = 16,
    parameter int RING_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              advance,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [31:0]       tail_ptr,
    output logic              idle
);
    localparam int HI_W       = ADDR_W - 32;
    localparam int ALIGN_BITS = $clog2(DATA_BUS_BYTES);

    logic              run, start_pulse, fresh;
    logic [HI_W-1:0]   base_hi;
    logic [31:0]       base_lo, tail, cur_lo;
    logic [RING_W-1:0] ring_last;

    ring_ptr_regs #(.HI_W(HI_W), .RING_W(RING_W), .ALIGN_BITS(ALIGN_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
        .run(run), .start_pulse(start_pulse), .fresh(fresh), .base_hi(base_hi),
        .base_lo(base_lo), .tail(tail), .ring_last(ring_last)
    );

    ring_ptr_cursor #(.RING_W(RING_W), .DESC_BYTES(DESC_BYTES), .ALIGN_BITS(ALIGN_BITS)) u_cursor (
        .clk(clk), .rst_n(rst_n), .run(run), .start_pulse(start_pulse), .fresh(fresh),
        .base_lo(base_lo), .tail(tail), .ring_last(ring_last), .advance(advance),
        .cur_lo(cur_lo), .idle(idle)
    );

    // Output assembly: upper address bits come straight from the high base.
    always_comb begin
        cur_addr = {base_hi, cur_lo};
        tail_ptr = tail;
    end

    // Register read mux.
    always_comb begin
        case (reg_addr)
            RA_CTRL:      reg_rdata = {31'b0, run};
            RA_BASE_HI:   reg_rdata = 32'(base_hi);
            RA_BASE_LO:   reg_rdata = base_lo;
            RA_TAIL:      reg_rdata = tail;
            RA_RING_LAST: reg_rdata = 32'(ring_last);
            RA_CUR_LO:    reg_rdata = cur_lo;
            default:      reg_rdata = '0;
        endcase
    end

    // R7: upper pointer bits track the high base half
    a_r7_upper: assert property (@(posedge clk) disable iff (!rst_n)
        cur_addr[ADDR_W-1:32] == base_hi);
endmodule

// File: tb/desc_ring_ptr_bench.sv
module desc_ring_ptr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        advance = 1'b0;
    logic [47:0] cur_addr;
    logic [31:0] tail_ptr;
    logic        idle;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    desc_ring_ptr u_desc_ring_ptr (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .advance(advance),
        .cur_addr(cur_addr), .tail_ptr(tail_ptr), .idle(idle)
    );

    // op: 0 write, 1 read-compare, 2 advance then compare offset 5
    localparam int NV = 39;
    localparam logic [76:0] VEC [0:NV-1] = '{
        {2'd1, 8'd1,  3'd0, 32'h0,         32'h0},          // R1 ctrl
        {2'd1, 8'd1,  3'd5, 32'h0,         32'h0},          // R1 cur
        {2'd1, 8'd12, 3'd6, 32'h0,         32'h0},          // R12 unmapped
        {2'd0, 8'd0,  3'd1, 32'h0000_00AB, 32'h0},
        {2'd0, 8'd0,  3'd2, 32'h1000_0007, 32'h0},
        {2'd1, 8'd3,  3'd2, 32'h0,         32'h1000_0000},  // R3 aligned
        {2'd1, 8'd2,  3'd1, 32'h0,         32'h0000_00AB},
        {2'd0, 8'd0,  3'd4, 32'h3,         32'h0},
        {2'd0, 8'd0,  3'd3, 32'h1000_0030, 32'h0},
        {2'd1, 8'd8,  3'd3, 32'h0,         32'h1000_0030},  // R8
        {2'd0, 8'd0,  3'd0, 32'h1,         32'h0},
        {2'd1, 8'd5,  3'd5, 32'h0,         32'h1000_0000},  // R5 load
        {2'd1, 8'd2,  3'd0, 32'h0,         32'h1},
        {2'd2, 8'd9,  3'd5, 32'h0,         32'h1000_0010},  // R9
        {2'd2, 8'd9,  3'd5, 32'h0,         32'h1000_0020},  // R9
        {2'd2, 8'd9,  3'd5, 32'h0,         32'h1000_0030},  // R9 reaches tail
        {2'd2, 8'd11, 3'd5, 32'h0,         32'h1000_0030},  // R11 idle hold
        {2'd0, 8'd0,  3'd3, 32'h2000_0000, 32'h0},
        {2'd2, 8'd10, 3'd5, 32'h0,         32'h1000_0000},  // R10 wrap
        {2'd0, 8'd0,  3'd2, 32'h5555_0000, 32'h0},
        {2'd1, 8'd2,  3'd2, 32'h0,         32'h1000_0000},  // R2 lo frozen
        {2'd0, 8'd0,  3'd1, 32'h0000_0077, 32'h0},
        {2'd1, 8'd2,  3'd1, 32'h0,         32'h0000_00AB},  // R2 hi frozen
        {2'd2, 8'd9,  3'd5, 32'h0,         32'h1000_0010},  // R9
        {2'd0, 8'd0,  3'd0, 32'h0,         32'h0},
        {2'd2, 8'd11, 3'd5, 32'h0,         32'h1000_0010},  // R11 stopped
        {2'd0, 8'd0,  3'd5, 32'hDEAD_0000, 32'h0},
        {2'd1, 8'd12, 3'd5, 32'h0,         32'h1000_0010},  // R12 read-only
        {2'd0, 8'd0,  3'd0, 32'h1,         32'h0},
        {2'd1, 8'd6,  3'd5, 32'h0,         32'h1000_0010},  // R6 resume
        {2'd0, 8'd0,  3'd0, 32'h0,         32'h0},
        {2'd0, 8'd0,  3'd1, 32'h0000_0012, 32'h0},
        {2'd1, 8'd4,  3'd1, 32'h0,         32'h0000_0012},  // R4
        {2'd0, 8'd0,  3'd0, 32'h1,         32'h0},
        {2'd1, 8'd4,  3'd5, 32'h0,         32'h1000_0010},  // R4 no reload
        {2'd0, 8'd0,  3'd0, 32'h0,         32'h0},
        {2'd0, 8'd0,  3'd2, 32'h3000_0008, 32'h0},
        {2'd0, 8'd0,  3'd0, 32'h1,         32'h0},
        {2'd1, 8'd5,  3'd5, 32'h0,         32'h3000_0008}   // R5 reload
    };

    task automatic check(input int req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input int req, input logic [2:0] a, input logic [31:0] e);
        @(negedge clk); reg_addr = a; #1;
        check(req, 48'(reg_rdata), 48'(e));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            op = VEC[i][76:75];
            if (op == 2'd0) wr(VEC[i][66:64], VEC[i][63:32]);
            else if (op == 2'd1) rd(int'(VEC[i][74:67]), VEC[i][66:64], VEC[i][31:0]);
            else begin
                @(negedge clk); advance = 1'b1;
                @(negedge clk); advance = 1'b0;
                rd(int'(VEC[i][74:67]), 3'd5, VEC[i][31:0]);
            end
        end
        // R7: upper bits follow high base half
        check(7, {32'h0, cur_addr[47:32]}, 48'h12);
        check(7, cur_addr, 48'h0012_3000_0008);
        // R11: not idle away from tail
        check(11, 48'(idle), 48'd0);
        // R8: tail port
        check(8, 48'(tail_ptr), 48'h2000_0000);
        // R10: ring length readback
        rd(10, 3'd4, 32'h3);
        // R1: reset from a running state
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(1, 3'd0, 32'h0);
        rd(1, 3'd2, 32'h0);
        rd(1, 3'd3, 32'h0);
        check(1, cur_addr, 48'h0);
        check(1, 48'(idle), 48'd1);
        // R1/R6: flag cleared by reset, so a start keeps the pointer at zero
        wr(3'd3, 32'h100);
        wr(3'd0, 32'h1);
        rd(1, 3'd5, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule